// File: doc/BRIEF.md
# Indexed-Address Host Bus Memory Port

This block lets an external processor reach a 256-byte internal memory through a narrow asynchronous bus. The bus has an 8-bit data path, an active-low chip select, active-low read and write strobes, and one address bit. The data path is split into an input, an output and an output enable, ready for a bidirectional pad. A write with the address bit low stores the data byte into an internal pointer. A read or write with the address bit high then reaches the memory byte that the pointer names. After each such data access the pointer moves on by one. A burst of N bytes therefore takes one pointer write and N data cycles.

The pins are synchronized to the internal clock. A cycle is recognised when it ends: when the strobe or the chip select goes inactive, whichever comes first. The write data and the address bit are taken from the last synchronized sample in which the cycle was still active. The lower part of the memory holds control registers and the upper part holds data buffers. A mode input sets where the two parts meet. An output flag tells downstream logic whether the pointer is in the buffer part.

Top module: `hbus_mem_port`

## Requirements
- R1: After reset the pointer is 0x00, the output enable is low and, in host mode, the region flag is low. A data write made with no pointer write first lands at address 0x00.
- R2: A write cycle with the address bit at 0 loads the pointer from the data byte and changes no memory byte.
- R3: A write cycle with the address bit at 1 stores the data byte at the address the pointer holds.
- R4: A read cycle with the address bit at 1 drives the byte at the pointer's address onto the data output.
- R5: The pointer advances by exactly one after each completed data cycle (read or write with the address bit at 1). A pointer-load cycle does not advance it.
- R6: On an advance from 0xFF the pointer wraps to 0x00.
- R7: The output enable is high only while chip select, the read strobe and the address bit are all active, with the address bit at 1. It is low during write cycles.
- R8: A cycle ends at the first deassertion of either its strobe or chip select. A write stores the byte present at that moment, and a data change after it has no effect. A cycle advances the pointer once.
- R9: The region flag is 1 when the pointer is at or above the buffer base. The base is 0x10 in host mode (mode input 0) and 0x40 in peripheral mode (mode input 1).
- R10: A read cycle with the address bit at 0 leaves the output enable low and does not move the pointer.
- R11: Strobes given while chip select is inactive change neither the memory nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_a0 | input | 1 | 0 selects the pointer, 1 selects the data byte |
| bus_d_in | input | 8 | Data from the processor |
| bus_d_out | output | 8 | Data to the processor |
| bus_d_oe | output | 1 | Enable for the data output pad |
| mode_periph | input | 1 | 0 host layout, 1 peripheral layout |
| region_buf | output | 1 | Pointer lies in the buffer region |

## Verification
A wrong pointer shows at the ports in two ways. The region flag flips at the wrong time as the pointer crosses a region base. The wrong byte comes back on the next data read. Both show within one bus cycle, about three clocks after the strobe is released. A cycle-end detector that fires twice or fires late shows as a skipped byte in a read-back burst. A detector that takes the data too late shows as a late-changed value being stored, which the bench provokes on purpose.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] ptr_t;

    // One synchronized view of the processor pins
    typedef struct packed {
        logic  cs_n;
        logic  rd_n;
        logic  wr_n;
        logic  a0;
        byte_t data;
    } pin_sample_t;

    localparam pin_sample_t PIN_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                         a0: 1'b0, data: '0};

    // Completed-cycle classification, reported on the cycle's end
    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_ADDR  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_READ  = 2'd3
    } cyc_kind_t;

    localparam ptr_t HOST_BUF_BASE   = 8'h10;
    localparam ptr_t PERIPH_BUF_BASE = 8'h40;

    function automatic logic wr_active(pin_sample_t s);
        return !s.cs_n && !s.wr_n;
    endfunction

    function automatic logic rd_active(pin_sample_t s);
        return !s.cs_n && !s.rd_n;
    endfunction

    function automatic logic in_buffer(ptr_t p, logic periph, ptr_t host_base, ptr_t per_base);
        return p >= (periph ? per_base : host_base);
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync
    import hbus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  pin_sample_t d,
    output pin_sample_t q
);
    pin_sample_t stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= PIN_IDLE;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_cycle_decode.sv
module hbus_cycle_decode
    import hbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_sample_t cur,
    output cyc_kind_t   kind,
    output byte_t       data
);
    pin_sample_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= PIN_IDLE;
        else     prev <= cur;
    end

    logic w_end, r_end;
    assign w_end = wr_active(prev) && !wr_active(cur);
    assign r_end = rd_active(prev) && !rd_active(cur);

    // prev is the last sample in which the cycle was still active
    always_comb begin
        kind = CYC_NONE;
        if (w_end)               kind = prev.a0 ? CYC_WRITE : CYC_ADDR;
        else if (r_end && prev.a0) kind = CYC_READ;
    end

    assign data = prev.data;
endmodule

// File: rtl/hbus_ram.sv
module hbus_ram #(
    parameter int DW = 8,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/hbus_mem_port.sv
module hbus_mem_port
    import hbus_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter ptr_t HOST_BASE   = HOST_BUF_BASE,
    parameter ptr_t PERIPH_BASE = PERIPH_BUF_BASE
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_cs_n,
    input  logic                        bus_rd_n,
    input  logic                        bus_wr_n,
    input  logic                        bus_a0,
    input  logic [hbus_pkg::DATA_W-1:0] bus_d_in,
    output logic [hbus_pkg::DATA_W-1:0] bus_d_out,
    output logic                        bus_d_oe,
    input  logic                        mode_periph,
    output logic                        region_buf
);
    pin_sample_t raw, synced;
    cyc_kind_t   cyc_kind;
    byte_t       evt_data;
    ptr_t        ptr_q;
    byte_t       ram_rdata;

    assign raw = '{cs_n: bus_cs_n, rd_n: bus_rd_n, wr_n: bus_wr_n,
                   a0: bus_a0, data: bus_d_in};

    hbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    hbus_cycle_decode u_dec (
        .clk  (clk),
        .rst  (rst),
        .cur  (synced),
        .kind (cyc_kind),
        .data (evt_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            unique case (cyc_kind)
                CYC_ADDR:            ptr_q <= evt_data;
                CYC_WRITE, CYC_READ: ptr_q <= ptr_q + 1'b1;
                default:             ptr_q <= ptr_q;
            endcase
        end
    end

    hbus_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (cyc_kind == CYC_WRITE),
        .waddr (ptr_q),
        .wdata (evt_data),
        .raddr (ptr_q),
        .rdata (ram_rdata)
    );

    // Pad enable follows the raw pins so the bus is released at once
    assign bus_d_oe   = !bus_cs_n && !bus_rd_n && bus_a0;
    assign bus_d_out  = ram_rdata;
    assign region_buf = in_buffer(ptr_q, mode_periph, HOST_BASE, PERIPH_BASE);
endmodule

// File: rtl/hbus_mem_port_chk.sv
module hbus_mem_port_chk
    import hbus_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bus_cs_n,
    input logic      bus_rd_n,
    input logic      bus_a0,
    input logic      bus_d_oe,
    input logic      mode_periph,
    input logic      region_buf,
    input cyc_kind_t cyc_kind,
    input byte_t     evt_data,
    input ptr_t      ptr_q
);
    // R1: pointer cleared by reset
    p_reset_ptr_r1: assert property (@(posedge clk) rst |=> ptr_q == '0);

    // R2: pointer load takes the cycle's data byte
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        cyc_kind == CYC_ADDR |=> ptr_q == $past(evt_data));

    // R5 / R6: single step per data cycle, wrapping at the top
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc_kind == CYC_WRITE || cyc_kind == CYC_READ) |=> ptr_q == $past(ptr_q) + 8'd1);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cyc_kind == CYC_NONE |=> $stable(ptr_q));

    // R7: pad enabled only during a selected data read
    p_oe_pins_r7: assert property (@(posedge clk) disable iff (rst)
        bus_d_oe |-> (!bus_cs_n && !bus_rd_n && bus_a0));

    // R9: region flag agrees with pointer and layout
    p_region_r9: assert property (@(posedge clk) disable iff (rst)
        region_buf == (ptr_q >= (mode_periph ? PERIPH_BUF_BASE : HOST_BUF_BASE)));
endmodule

bind hbus_mem_port hbus_mem_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_cs_n    (bus_cs_n),
    .bus_rd_n    (bus_rd_n),
    .bus_a0      (bus_a0),
    .bus_d_oe    (bus_d_oe),
    .mode_periph (mode_periph),
    .region_buf  (region_buf),
    .cyc_kind    (cyc_kind),
    .evt_data    (evt_data),
    .ptr_q       (ptr_q)
);

// File: tb/hbus_mem_port_bench.sv
module hbus_mem_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, mode = 1'b0;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out;
    logic       oe, region;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    hbus_mem_port u_hbus_mem_port (
        .clk         (clk),
        .rst         (rst),
        .bus_cs_n    (cs_n),
        .bus_rd_n    (rd_n),
        .bus_wr_n    (wr_n),
        .bus_a0      (a0),
        .bus_d_in    (d_in),
        .bus_d_out   (d_out),
        .bus_d_oe    (oe),
        .mode_periph (mode),
        .region_buf  (region)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle; sampled output taken just before release
    task automatic bus_cycle(input logic sel, input logic is_rd, input logic addr_bit,
                             input logic [7:0] data, output logic [7:0] got,
                             output logic oe_seen);
        @(negedge clk);
        a0 = addr_bit; d_in = data; cs_n = !sel;
        if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
        repeat (4) @(negedge clk);
        got = d_out; oe_seen = oe;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    logic [7:0] g;
    logic       o;

    task automatic do_addr(input logic [7:0] p);
        bus_cycle(1'b1, 1'b0, 1'b0, p, g, o);
    endtask

    task automatic do_wr(input logic [7:0] v);
        bus_cycle(1'b1, 1'b0, 1'b1, v, g, o);
    endtask

    task automatic do_rd(input string req, input logic [7:0] exp);
        bus_cycle(1'b1, 1'b1, 1'b1, 8'h00, g, o);
        check(req, g, exp);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // {op(0 pointer,1 write,2 read), data, expected read, expected region}
    localparam int NV = 20;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 8'h10, 8'h00, 1'b1},
        {2'd1, 8'h80, 8'h00, 1'b1},
        {2'd1, 8'h06, 8'h00, 1'b1},
        {2'd0, 8'h10, 8'h00, 1'b1},
        {2'd2, 8'h00, 8'h80, 1'b1},
        {2'd2, 8'h00, 8'h06, 1'b1},
        {2'd0, 8'hFE, 8'h00, 1'b1},
        {2'd1, 8'hA1, 8'h00, 1'b1},
        {2'd1, 8'hA2, 8'h00, 1'b0},
        {2'd1, 8'hA3, 8'h00, 1'b0},
        {2'd0, 8'hFE, 8'h00, 1'b1},
        {2'd2, 8'h00, 8'hA1, 1'b1},
        {2'd2, 8'h00, 8'hA2, 1'b0},
        {2'd2, 8'h00, 8'hA3, 1'b0},
        {2'd0, 8'h0E, 8'h00, 1'b0},
        {2'd1, 8'h11, 8'h00, 1'b0},
        {2'd1, 8'h22, 8'h00, 1'b1},
        {2'd0, 8'h0E, 8'h00, 1'b0},
        {2'd2, 8'h00, 8'h11, 1'b0},
        {2'd2, 8'h00, 8'h22, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state at the ports
        check("R1 oe", {7'd0, oe}, 8'h00);
        check("R1 region", {7'd0, region}, 8'h00);
        do_wr(8'h5C);
        do_addr(8'h00);
        do_rd("R1 first write at 0x00", 8'h5C);

        // Table walk: R2 pointer loads, R3 writes, R4 reads, R6 wrap, R9 region
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][18:17];
            if (op == 2'd0) do_addr(VEC[i][16:9]);
            else if (op == 2'd1) do_wr(VEC[i][16:9]);
            else do_rd("R4/R3/R6 table read", VEC[i][8:1]);
            check("R9/R2 table region", {7'd0, region}, {7'd0, VEC[i][0]});
        end

        // R6: wrap read-back
        do_addr(8'hFF);
        do_rd("R6 byte at 0xFF", 8'hA2);
        check("R6 pointer wrapped", {7'd0, region}, 8'h00);
        do_rd("R6 byte at 0x00", 8'hA3);

        // R2: pointer load leaves memory intact
        do_addr(8'h10);
        do_rd("R2 no store on load", 8'h80);

        // R5: load does not step, data cycle steps once
        do_addr(8'h0F);
        repeat (6) @(negedge clk);
        check("R5 no step on load", {7'd0, region}, 8'h00);
        bus_cycle(1'b1, 1'b1, 1'b1, 8'h00, g, o);
        check("R7 oe during read", {7'd0, o}, 8'h01);
        check("R5 step after read", {7'd0, region}, 8'h01);

        // R7: no drive during a data write
        do_addr(8'h30);
        bus_cycle(1'b1, 1'b0, 1'b1, 8'h44, g, o);
        check("R7 oe during write", {7'd0, o}, 8'h00);

        // R10: read with address bit low
        do_addr(8'h0F);
        bus_cycle(1'b1, 1'b1, 1'b0, 8'h00, g, o);
        check("R10 oe", {7'd0, o}, 8'h00);
        check("R10 pointer held", {7'd0, region}, 8'h00);

        // R11: strobes without chip select
        do_wr(8'h33);
        do_addr(8'h0F);
        bus_cycle(1'b0, 1'b0, 1'b1, 8'h55, g, o);
        check("R11 pointer held", {7'd0, region}, 8'h00);
        do_rd("R11 memory held", 8'h33);

        // R8: chip select released first, data changed afterwards
        do_addr(8'h20);
        @(negedge clk);
        a0 = 1'b1; d_in = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        d_in = 8'hC3;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        // R8: strobe released first, then chip select
        @(negedge clk);
        a0 = 1'b1; d_in = 8'h77; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        d_in = 8'h99;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        do_addr(8'h20);
        do_rd("R8 cs-first byte", 8'h5A);
        do_rd("R8 strobe-first byte, one step each", 8'h77);

        // R9: peripheral layout boundary
        mode = 1'b1;
        do_addr(8'h3F);
        check("R9 periph 0x3F", {7'd0, region}, 8'h00);
        do_addr(8'h40);
        check("R9 periph 0x40", {7'd0, region}, 8'h01);
        mode = 1'b0;
        @(negedge clk);
        check("R9 host 0x40", {7'd0, region}, 8'h01);

        summary();
    end
endmodule